// File: doc/BRIEF.md
# Laser Fault Latch and Protection Controller

This block turns raw fault indications from a laser driver's analog side into a latched error report and a latched protection command. It watches two supply flags (under-voltage and over-voltage) and a 4-bit digitised light-monitor code. It compares that code against an upper and a lower 4-bit limit. The playback or record mode input picks which pair of limits is in force. Each fault source must persist for a programmable number of clock cycles before it is accepted, which suppresses noise.

A change of the record/playback input opens a programmable blanking window. During that window, light-level violations are thrown away while the monitor settles. Supply faults are not blanked. An accepted fault drives the active-low error output low. If protection is enabled, the fault also latches a protection state that turns the driver currents off and engages the shunt. Both latches hold until software writes the error-clear bit. A separate laser-disable input forces the drive off at any time. The HF-module control output follows the mode input: low means the module is on in playback, high means it is off in record.

Top module: `ldp_fault_ctrl`

## Requirements
- R1: After reset, err_n is 1, prot_active, shunt_on and drive_off are 0 (with laser_dis low), and hf_en_n is 0.
- R2: A supply flag (sup_uv or sup_ov) held for filt_cycles consecutive cycles drives err_n low on the clock edge that completes the count. The supply path is not blanked by a mode change. A filt_cycles of 0 acts as 1.
- R3: A light violation exists when light_code is strictly greater than the active upper limit or strictly less than the active lower limit. A code equal to either limit is not a violation.
- R4: With hf_en_n at 0 (playback), the limits in force are play_over_thr and play_under_thr. With hf_en_n at 1 (record), they are rec_over_thr and rec_under_thr.
- R5: Once err_n is low, it stays low after the fault condition goes away, until err_clr_wr is pulsed. The same holds for prot_active.
- R6: A clear pulse always releases the latches on its own edge. If the fault condition is still present and its filter count is already met, err_n goes low again on the following edge.
- R7: When prot_en is 1, an accepted fault also sets prot_active, shunt_on and drive_off. When prot_en is 0, a fault lowers err_n but leaves prot_active and shunt_on at 0.
- R8: Each change of rec_mode blanks light violations on that edge and on the next mask_cycles edges. The light persistence count restarts after the window.
- R9: A fault condition that lasts fewer than filt_cycles consecutive cycles leaves err_n high.
- R10: While laser_dis is 1, drive_off is 1 whatever the fault state. laser_dis alone does not set shunt_on.
- R11: hf_en_n equals rec_mode delayed by one clock: 1 in record (module off), 0 in playback (module on).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rec_mode | input | 1 | 1 = record, 0 = playback |
| sup_uv | input | 1 | Supply under-voltage flag |
| sup_ov | input | 1 | Supply over-voltage flag |
| light_code | input | 4 | Digitised light-monitor level |
| play_over_thr | input | 4 | Upper light limit in playback |
| play_under_thr | input | 4 | Lower light limit in playback |
| rec_over_thr | input | 4 | Upper light limit in record |
| rec_under_thr | input | 4 | Lower light limit in record |
| mask_cycles | input | CNT_W | Blanking length after a mode change |
| filt_cycles | input | CNT_W | Persistence count for faults |
| prot_en | input | 1 | 1 allows faults to latch protection |
| err_clr_wr | input | 1 | One-cycle write of the error-clear bit |
| laser_dis | input | 1 | 1 forces the laser drive off |
| err_n | output | 1 | Active-low latched error |
| prot_active | output | 1 | Latched protection state |
| drive_off | output | 1 | Driver currents off command |
| shunt_on | output | 1 | Shunt engage command |
| hf_en_n | output | 1 | HF module control, low = on |

## Verification
The hardest case to reach is the exact edge at which a light violation is accepted after a mode change. Reaching it means the blanking window must run out and the persistence count must then complete from zero. The stimulus changes the mode and applies an out-of-range code on the same cycle. It then samples err_n on the edge just before and the edge just on the computed count, which is the change edge plus mask_cycles plus filt_cycles.

A second hard case is a clear written while the condition persists. The stimulus holds the supply flag through the clear pulse and checks for one high cycle of err_n followed by a fall.

// File: rtl/ldp_pkg.sv
package ldp_pkg;
    localparam int LVL_W = 4;

    typedef struct packed {
        logic [LVL_W-1:0] over;
        logic [LVL_W-1:0] under;
    } lim_pair_t;

    typedef enum logic {
        SRC_SUPPLY = 1'b0,
        SRC_LIGHT  = 1'b1
    } src_e;
endpackage

// File: rtl/ldp_mode_blank.sv
module ldp_mode_blank #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_mode,
    input  logic [CNT_W-1:0] mask_cycles,
    output logic             rec_q_o,
    output logic             blank_o
);
    typedef struct packed {
        logic             rec;
        logic [CNT_W-1:0] left;
    } blank_st_t;

    blank_st_t st_d, st_q;
    logic      changed;

    always_comb begin
        st_d    = st_q;
        changed = (rec_mode != st_q.rec);
        st_d.rec = rec_mode;
        if (changed) begin
            st_d.left = mask_cycles;
        end else if (st_q.left != '0) begin
            st_d.left = st_q.left - 1'b1;
        end
        blank_o = changed || (st_q.left != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rec_q_o = st_q.rec;
endmodule

// File: rtl/ldp_level_cmp.sv
module ldp_level_cmp
    import ldp_pkg::*;
(
    input  logic             rec_sel,
    input  logic [LVL_W-1:0] level,
    input  lim_pair_t        play_lim,
    input  lim_pair_t        rec_lim,
    output logic             viol_o
);
    lim_pair_t act_lim;
    logic      too_high;
    logic      too_low;

    always_comb begin
        act_lim  = rec_sel ? rec_lim : play_lim;
        too_high = (level > act_lim.over);
        too_low  = (level < act_lim.under);
        viol_o   = too_high || too_low;
    end
endmodule

// File: rtl/ldp_persist.sv
module ldp_persist #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             raw,
    input  logic [CNT_W-1:0] need,
    output logic             hit_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] run_d, run_q;
    logic [CNT_W:0]   run_next;

    always_comb begin
        run_next = {1'b0, run_q} + 1'b1;
        if (!raw) begin
            run_d = '0;
        end else if (run_q == CNT_MAX) begin
            run_d = run_q;
        end else begin
            run_d = run_q + 1'b1;
        end
        hit_o = raw && (run_next >= {1'b0, need});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else begin
            run_q <= run_d;
        end
    end
endmodule

// File: rtl/ldp_fault_ctrl.sv
module ldp_fault_ctrl
    import ldp_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_mode,
    input  logic             sup_uv,
    input  logic             sup_ov,
    input  logic [3:0]       light_code,
    input  logic [3:0]       play_over_thr,
    input  logic [3:0]       play_under_thr,
    input  logic [3:0]       rec_over_thr,
    input  logic [3:0]       rec_under_thr,
    input  logic [CNT_W-1:0] mask_cycles,
    input  logic [CNT_W-1:0] filt_cycles,
    input  logic             prot_en,
    input  logic             err_clr_wr,
    input  logic             laser_dis,
    output logic             err_n,
    output logic             prot_active,
    output logic             drive_off,
    output logic             shunt_on,
    output logic             hf_en_n
);
    localparam int NSRC = 2;

    typedef struct packed {
        logic err;
        logic prot;
    } latch_st_t;

    latch_st_t       st_d, st_q;
    logic            rec_q;
    logic            blank;
    logic            light_viol;
    logic [NSRC-1:0] raw_vec;
    logic [NSRC-1:0] hit_vec;
    lim_pair_t       play_lim;
    lim_pair_t       rec_lim;
    logic            fault_set;

    assign play_lim = '{over: play_over_thr, under: play_under_thr};
    assign rec_lim  = '{over: rec_over_thr,  under: rec_under_thr};

    ldp_mode_blank #(.CNT_W(CNT_W)) blank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec_mode   (rec_mode),
        .mask_cycles(mask_cycles),
        .rec_q_o    (rec_q),
        .blank_o    (blank)
    );

    ldp_level_cmp cmp_i (
        .rec_sel (rec_q),
        .level   (light_code),
        .play_lim(play_lim),
        .rec_lim (rec_lim),
        .viol_o  (light_viol)
    );

    assign raw_vec[SRC_SUPPLY] = sup_uv | sup_ov;
    assign raw_vec[SRC_LIGHT]  = light_viol & ~blank;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        ldp_persist #(.CNT_W(CNT_W)) persist_i (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_vec[s]),
            .need (filt_cycles),
            .hit_o(hit_vec[s])
        );
    end

    always_comb begin
        st_d      = st_q;
        fault_set = |hit_vec;
        if (err_clr_wr) begin
            st_d.err  = 1'b0;
            st_d.prot = 1'b0;
        end else begin
            st_d.err  = st_q.err  | fault_set;
            st_d.prot = st_q.prot | (fault_set & prot_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign err_n       = ~st_q.err;
    assign prot_active = st_q.prot;
    assign shunt_on    = st_q.prot;
    assign drive_off   = st_q.prot | laser_dis;
    assign hf_en_n     = rec_q;
endmodule

// File: rtl/ldp_fault_ctrl_chk.sv
module ldp_fault_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic rec_mode,
    input logic prot_en,
    input logic err_clr_wr,
    input logic laser_dis,
    input logic err_n,
    input logic prot_active,
    input logic drive_off,
    input logic hf_en_n
);
    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!err_n && !err_clr_wr) |=> !err_n);

    a_r6_clear_release: assert property (@(posedge clk) disable iff (!rst_n)
        err_clr_wr |=> (err_n && !prot_active));

    a_r7_prot_has_err: assert property (@(posedge clk) disable iff (!rst_n)
        prot_active |-> !err_n);

    a_r7_masked_no_prot: assert property (@(posedge clk) disable iff (!rst_n)
        (!prot_active && !prot_en) |=> !prot_active);

    a_r10_dis_forces_off: assert property (@(posedge clk) disable iff (!rst_n)
        laser_dis |-> drive_off);

    a_r11_hf_follows_mode: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (hf_en_n == $past(rec_mode)));
endmodule

bind ldp_fault_ctrl ldp_fault_ctrl_chk chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rec_mode   (rec_mode),
    .prot_en    (prot_en),
    .err_clr_wr (err_clr_wr),
    .laser_dis  (laser_dis),
    .err_n      (err_n),
    .prot_active(prot_active),
    .drive_off  (drive_off),
    .hf_en_n    (hf_en_n)
);

// File: tb/ldp_fault_ctrl_tb_top.sv
module ldp_fault_ctrl_tb_top;
    localparam int CNT_W = 8;
    localparam logic [3:0] SAFE = 4'd7;
    localparam int NVEC = 11;
    // vector: {expected fault, rec_mode, light_code[3:0]}
    // limits: playback lower 4 upper 11, record lower 6 upper 9
    localparam logic [5:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 4'd3},  {1'b0, 1'b0, 4'd4},  {1'b0, 1'b0, 4'd11},
        {1'b1, 1'b0, 4'd12}, {1'b1, 1'b1, 4'd5},  {1'b0, 1'b1, 4'd6},
        {1'b0, 1'b1, 4'd9},  {1'b1, 1'b1, 4'd10}, {1'b0, 1'b0, 4'd5},
        {1'b1, 1'b1, 4'd11}, {1'b0, 1'b0, 4'd10}
    };

    logic clk = 0;
    logic rst_n = 0;
    logic rec_mode = 0, sup_uv = 0, sup_ov = 0;
    logic [3:0] light_code = SAFE;
    logic [CNT_W-1:0] mask_cycles = '0, filt_cycles = 8'd1;
    logic prot_en = 0, err_clr_wr = 0, laser_dis = 0;
    logic err_n, prot_active, drive_off, shunt_on, hf_en_n;
    int checks = 0, failures = 0;

    always #5 clk = ~clk;

    ldp_fault_ctrl #(.CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .rec_mode(rec_mode), .sup_uv(sup_uv),
        .sup_ov(sup_ov), .light_code(light_code),
        .play_over_thr(4'd11), .play_under_thr(4'd4),
        .rec_over_thr(4'd9), .rec_under_thr(4'd6),
        .mask_cycles(mask_cycles), .filt_cycles(filt_cycles),
        .prot_en(prot_en), .err_clr_wr(err_clr_wr), .laser_dis(laser_dis),
        .err_n(err_n), .prot_active(prot_active), .drive_off(drive_off),
        .shunt_on(shunt_on), .hf_en_n(hf_en_n)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_pulse();
        err_clr_wr = 1;
        tick(1);
        err_clr_wr = 0;
        tick(1);
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        tick(2);
        rst_n = 1;
        tick(1);
        // R1 reset state
        chk("R1 err_n", err_n, 1'b1);
        chk("R1 prot_active", prot_active, 1'b0);
        chk("R1 shunt_on", shunt_on, 1'b0);
        chk("R1 drive_off", drive_off, 1'b0);
        chk("R1 hf_en_n", hf_en_n, 1'b0);

        // R3 / R4 compare table, filter 1, no blanking beyond change edge
        for (int i = 0; i < NVEC; i++) begin
            rec_mode   = VEC[i][4];
            light_code = VEC[i][3:0];
            tick(3);
            chk("R3 R4 limit compare", err_n, ~VEC[i][5]);
            light_code = SAFE;
            clear_pulse();
        end

        // R9 short supply glitch, then R2 full persistence, R7 protection
        filt_cycles = 8'd3;
        prot_en = 1;
        sup_ov = 1;
        tick(2);
        sup_ov = 0;
        chk("R9 supply glitch ignored", err_n, 1'b1);
        tick(1);
        sup_uv = 1;
        tick(2);
        chk("R2 not yet accepted", err_n, 1'b1);
        tick(1);
        chk("R2 accepted on count", err_n, 1'b0);
        chk("R7 prot_active", prot_active, 1'b1);
        chk("R7 shunt_on", shunt_on, 1'b1);
        chk("R7 drive_off", drive_off, 1'b1);
        sup_uv = 0;
        tick(4);
        chk("R5 err sticky", err_n, 1'b0);
        chk("R5 prot sticky", prot_active, 1'b1);
        clear_pulse();
        chk("R5 err cleared", err_n, 1'b1);
        chk("R5 prot cleared", prot_active, 1'b0);

        // R6 clear while condition persists
        filt_cycles = 8'd1;
        sup_uv = 1;
        tick(1);
        chk("R6 set", err_n, 1'b0);
        err_clr_wr = 1;
        tick(1);
        chk("R6 released on clear edge", err_n, 1'b1);
        err_clr_wr = 0;
        tick(1);
        chk("R6 sets again", err_n, 1'b0);
        sup_uv = 0;
        clear_pulse();

        // R7 protection masked
        prot_en = 0;
        sup_ov = 1;
        tick(1);
        chk("R7 masked err", err_n, 1'b0);
        chk("R7 masked prot", prot_active, 1'b0);
        chk("R7 masked shunt", shunt_on, 1'b0);
        chk("R7 masked drive", drive_off, 1'b0);
        sup_ov = 0;
        clear_pulse();

        // R2 supply path ignores blanking; R11 hf follows mode
        mask_cycles = 8'd20;
        rec_mode = 1;
        sup_ov = 1;
        tick(1);
        chk("R2 supply not blanked", err_n, 1'b0);
        chk("R11 hf off in record", hf_en_n, 1'b1);
        sup_ov = 0;
        clear_pulse();
        rec_mode = 0;
        tick(25);
        chk("R11 hf on in playback", hf_en_n, 1'b0);

        // R8 blanking window: mask 5, filter 2 -> accepted on 8th edge
        mask_cycles = 8'd5;
        filt_cycles = 8'd2;
        rec_mode = 1;
        light_code = 4'd12;
        tick(7);
        chk("R8 still blanked", err_n, 1'b1);
        tick(1);
        chk("R8 accepted after window", err_n, 1'b0);
        light_code = SAFE;
        clear_pulse();

        // R9 short light glitch (record lower limit 6)
        filt_cycles = 8'd3;
        light_code = 4'd2;
        tick(2);
        light_code = SAFE;
        tick(3);
        chk("R9 light glitch ignored", err_n, 1'b1);

        // R10 laser disable
        laser_dis = 1;
        #1;
        chk("R10 drive off", drive_off, 1'b1);
        chk("R10 no shunt", shunt_on, 1'b0);
        laser_dis = 0;
        #1;
        chk("R10 drive restored", drive_off, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule